// File: doc/BRIEF.md
# CPU Presence Map

This block records which processors of a system are present, one bit per processor, for up to 256 identifiers held as a 32-byte map. A hotplug controller announces a processor arriving or leaving by pulsing a plug or unplug strobe together with the 8-bit identifier of that processor. The block sets or clears the matching bit, and for every request it accepts it raises a general-purpose event status bit for one cycle. The interrupt logic downstream uses that bit to decide whether to signal the host.

Software sees the map through a small byte-wide window. A read at byte offset N returns byte N of the map. Only single-byte accesses are valid, and writes are accepted but change nothing. At reset the map is loaded from a vector that lists the processors present at boot. Loading that boot set raises no event.

Top module: `cpu_presence_map`

## Requirements
- R1: A byte-sized read (req_size 0) at offset N answers one cycle later with rsp_vld=1, rsp_err=0, and rsp_data equal to byte N of the map. Bit k of byte N stands for processor 8N+k. The value returned is the map as it was before any update made on the same clock edge.
- R2: An accepted plug request for identifier id sets bit id%8 of byte id/8. Reads issued from the next cycle onward see the bit set.
- R3: An accepted unplug request for identifier id clears bit id%8 of byte id/8.
- R4: In the cycle after any cycle that holds at least one accepted request, gpe_set equals 8'h04 (bit 2 only). In every other cycle gpe_set is zero.
- R5: While rst is high, and in the cycle after it, gpe_set and rsp_vld are zero. After reset the map equals boot_map.
- R6: A write request (req_wr=1, req_size 0) leaves the map unchanged. It is answered with rsp_vld=1, rsp_err=0 and rsp_data=0.
- R7: A request whose req_size is not 0 (1 half, 2 word, 3 reserved) is answered with rsp_err=1 and rsp_data=0, and it changes nothing.
- R8: A request whose identifier gives id/8 ≥ NUM_BYTES is rejected. The map is unchanged and no event is raised.
- R9: If a plug and an unplug name the same identifier in one cycle, the bit ends cleared and a single event is raised.
- R10: A plug and an unplug for different identifiers in the same cycle are both applied.
- R11: In a cycle with no accepted request, the map keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads boot_map |
| boot_map | input | NUM_BYTES*8 | Processors present at boot, bit i = identifier i |
| plug_vld | input | 1 | Plug request strobe |
| plug_id | input | ID_W | Identifier of the processor being added |
| unplug_vld | input | 1 | Unplug request strobe |
| unplug_id | input | ID_W | Identifier of the processor being removed |
| req_vld | input | 1 | Window access request |
| req_wr | input | 1 | 1 = write (ignored), 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| req_addr | input | clog2(NUM_BYTES) | Byte offset into the window |
| rsp_vld | output | 1 | Response valid, one cycle after req_vld |
| rsp_err | output | 1 | Access size was not a byte |
| rsp_data | output | 8 | Read data byte |
| gpe_set | output | 8 | Event status set mask, bit 2 pulses per accepted request |

## Verification
The plug and unplug strobes are driven from a seeded random generator. Identifiers collide on purpose often enough to cover same-cycle plug/unplug of one processor as well as of two different ones, so the bench can tell set-then-clear ordering apart from clear priority. Reads run in the same cycles as updates, which shows whether a read returns the map from before the edge or after it. Directed cases cover the extreme identifiers 0 and 255, writes, non-byte sizes and the boot load. A second instance with a 16-byte map checks that an identifier beyond the map is rejected without an event, while one at the top edge of that map is still accepted.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

    localparam int BYTE_W     = 8;
    localparam int GPE_W      = 8;
    localparam int HP_GPE_BIT = 2;
    localparam logic [GPE_W-1:0] HP_GPE_MASK = GPE_W'(1) << HP_GPE_BIT;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic plug;
        logic unplug;
    } hp_evt_t;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [BYTE_W-1:0] data;
    } win_rsp_t;

    function automatic logic id_in_map(input logic [31:0] id, input int unsigned nbytes);
        return (id / BYTE_W) < nbytes;
    endfunction

endpackage

// File: rtl/cpuhp_req_decode.sv
module cpuhp_req_decode
    import cpuhp_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 8
) (
    input  logic                          plug_vld,
    input  logic [ID_W-1:0]               plug_id,
    input  logic                          unplug_vld,
    input  logic [ID_W-1:0]               unplug_id,
    output logic [NUM_BYTES*BYTE_W-1:0]   set_mask,
    output logic [NUM_BYTES*BYTE_W-1:0]   clr_mask,
    output hp_evt_t                       evt
);
    localparam int MAP_W = NUM_BYTES * BYTE_W;

    logic [31:0] plug_id_w;
    logic [31:0] unplug_id_w;

    assign plug_id_w   = 32'(plug_id);
    assign unplug_id_w = 32'(unplug_id);

    // Out-of-map identifiers are dropped here, before any mask is built.
    assign evt.plug   = plug_vld   && id_in_map(plug_id_w,   NUM_BYTES);
    assign evt.unplug = unplug_vld && id_in_map(unplug_id_w, NUM_BYTES);

    for (genvar i = 0; i < MAP_W; i++) begin : g_bit
        assign set_mask[i] = evt.plug   && (plug_id_w   == 32'(i));
        assign clr_mask[i] = evt.unplug && (unplug_id_w == 32'(i));
    end

endmodule

// File: rtl/cpuhp_map_store.sv
module cpuhp_map_store
    import cpuhp_pkg::*;
#(
    parameter int NUM_BYTES = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BYTES*BYTE_W-1:0] boot_map,
    input  logic [NUM_BYTES*BYTE_W-1:0] set_mask,
    input  logic [NUM_BYTES*BYTE_W-1:0] clr_mask,
    input  hp_evt_t                     evt,
    output logic [NUM_BYTES*BYTE_W-1:0] map_q,
    output logic [GPE_W-1:0]            gpe_set
);
    logic any_evt;
    assign any_evt = evt.plug || evt.unplug;

    // Clear is applied after set, so it wins on a shared bit.
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[b*BYTE_W +: BYTE_W] <= boot_map[b*BYTE_W +: BYTE_W];
            end else begin
                map_q[b*BYTE_W +: BYTE_W] <= (map_q[b*BYTE_W +: BYTE_W]
                                              | set_mask[b*BYTE_W +: BYTE_W])
                                             & ~clr_mask[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gpe_set <= '0;
        end else begin
            gpe_set <= any_evt ? HP_GPE_MASK : '0;
        end
    end

    // R11
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !any_evt |=> $stable(map_q));

    // R4
    gpe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        any_evt |=> gpe_set == HP_GPE_MASK);

    // R4
    gpe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !any_evt |=> gpe_set == '0);

endmodule

// File: rtl/cpuhp_win_port.sv
module cpuhp_win_port
    import cpuhp_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    parameter int AW        = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_BYTES*BYTE_W-1:0] map_i,
    input  logic                        req_vld,
    input  logic                        req_wr,
    input  acc_size_e                   req_size,
    input  logic [AW-1:0]               req_addr,
    output win_rsp_t                    rsp
);
    logic     size_ok;
    logic     rd_hit;
    win_rsp_t rsp_d;

    assign size_ok = (req_size == ACC_BYTE);
    assign rd_hit  = req_vld && !req_wr && size_ok && (int'(req_addr) < NUM_BYTES);

    always_comb begin
        rsp_d.vld  = req_vld;
        rsp_d.err  = req_vld && !size_ok;
        rsp_d.data = '0;
        if (rd_hit) begin
            rsp_d.data = map_i[int'(req_addr)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp <= rsp_d;
        end
    end

    // R7
    size_err_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld && (req_size != ACC_BYTE) |=> rsp.err && (rsp.data == '0));

    // R6
    wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld && req_wr |=> rsp.vld && (rsp.data == '0));

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp.vld);

endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
    import cpuhp_pkg::*;
#(
    parameter int NUM_BYTES = 32,
    parameter int ID_W      = 8,
    localparam int MAP_W    = NUM_BYTES * BYTE_W,
    localparam int AW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [MAP_W-1:0] boot_map,
    input  logic             plug_vld,
    input  logic [ID_W-1:0]  plug_id,
    input  logic             unplug_vld,
    input  logic [ID_W-1:0]  unplug_id,
    input  logic             req_vld,
    input  logic             req_wr,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    output logic             rsp_vld,
    output logic             rsp_err,
    output logic [7:0]       rsp_data,
    output logic [7:0]       gpe_set
);
    logic [MAP_W-1:0] set_mask;
    logic [MAP_W-1:0] clr_mask;
    logic [MAP_W-1:0] map_q;
    hp_evt_t          evt;
    win_rsp_t         rsp;

    cpuhp_req_decode #(
        .NUM_BYTES (NUM_BYTES),
        .ID_W      (ID_W)
    ) u_decode (
        .plug_vld   (plug_vld),
        .plug_id    (plug_id),
        .unplug_vld (unplug_vld),
        .unplug_id  (unplug_id),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .evt        (evt)
    );

    cpuhp_map_store #(
        .NUM_BYTES (NUM_BYTES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .boot_map (boot_map),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .evt      (evt),
        .map_q    (map_q),
        .gpe_set  (gpe_set)
    );

    cpuhp_win_port #(
        .NUM_BYTES (NUM_BYTES),
        .AW        (AW)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .map_i    (map_q),
        .req_vld  (req_vld),
        .req_wr   (req_wr),
        .req_size (acc_size_e'(req_size)),
        .req_addr (req_addr),
        .rsp      (rsp)
    );

    assign rsp_vld  = rsp.vld;
    assign rsp_err  = rsp.err;
    assign rsp_data = rsp.data;

    // R2
    plug_set_chk: assert property (@(posedge clk) disable iff (rst)
        evt.plug && !(evt.unplug && (unplug_id == plug_id)) |=> map_q[$past(plug_id)]);

    // R3
    unplug_clr_chk: assert property (@(posedge clk) disable iff (rst)
        evt.unplug |=> !map_q[$past(unplug_id)]);

    // R4
    gpe_shape_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gpe_set) <= 1);

endmodule

// File: tb/tb_cpu_presence_map.sv
module tb_cpu_presence_map;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // main instance, 32-byte map
    logic [255:0] boot_map;
    logic         plug_vld = 0, unplug_vld = 0, req_vld = 0, req_wr = 0;
    logic [7:0]   plug_id = 0, unplug_id = 0;
    logic [1:0]   req_size = 0;
    logic [4:0]   req_addr = 0;
    logic         rsp_vld, rsp_err;
    logic [7:0]   rsp_data, gpe_set;

    // reduced instance, 16-byte map
    logic [127:0] s_boot;
    logic         s_plug_vld = 0, s_unplug_vld = 0, s_req_vld = 0;
    logic [7:0]   s_plug_id = 0, s_unplug_id = 0;
    logic [3:0]   s_req_addr = 0;
    logic         s_rsp_vld, s_rsp_err;
    logic [7:0]   s_rsp_data, s_gpe_set;

    cpu_presence_map dut (
        .clk(clk), .rst(rst), .boot_map(boot_map),
        .plug_vld(plug_vld), .plug_id(plug_id),
        .unplug_vld(unplug_vld), .unplug_id(unplug_id),
        .req_vld(req_vld), .req_wr(req_wr), .req_size(req_size), .req_addr(req_addr),
        .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_data(rsp_data), .gpe_set(gpe_set)
    );

    cpu_presence_map #(.NUM_BYTES(16), .ID_W(8)) dut_small (
        .clk(clk), .rst(rst), .boot_map(s_boot),
        .plug_vld(s_plug_vld), .plug_id(s_plug_id),
        .unplug_vld(s_unplug_vld), .unplug_id(s_unplug_id),
        .req_vld(s_req_vld), .req_wr(1'b0), .req_size(2'd0), .req_addr(s_req_addr),
        .rsp_vld(s_rsp_vld), .rsp_err(s_rsp_err), .rsp_data(s_rsp_data), .gpe_set(s_gpe_set)
    );

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;
    logic [255:0] model;
    logic [127:0] s_model;

    function automatic logic [255:0] boot_pattern();
        logic [255:0] v;
        for (int i = 0; i < 256; i++) v[i] = (i % 3 == 0);
        return v;
    endfunction

    function automatic logic [127:0] small_pattern();
        logic [127:0] v;
        for (int i = 0; i < 128; i++) v[i] = (i % 5 == 0);
        return v;
    endfunction

    function automatic logic [7:0] exp_gpe(input logic any);
        return any ? 8'h04 : 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle on the main instance: drive at a falling edge, check at the next one.
    task automatic cycle(input logic pv, input logic [7:0] pid,
                         input logic uv, input logic [7:0] uid,
                         input logic rv, input logic rw, input logic [1:0] rs,
                         input logic [4:0] ra, input string tag);
        logic       e_vld, e_err;
        logic [7:0] e_data, e_gpe;
        e_vld  = rv;
        e_err  = rv && (rs != 2'd0);
        e_data = (rv && !rw && rs == 2'd0) ? model[ra*8 +: 8] : 8'h00;
        e_gpe  = exp_gpe(pv || uv);
        if (pv) model[pid] = 1'b1;
        if (uv) model[uid] = 1'b0;
        plug_vld = pv; plug_id = pid; unplug_vld = uv; unplug_id = uid;
        req_vld = rv; req_wr = rw; req_size = rs; req_addr = ra;
        @(negedge clk);
        plug_vld = 0; unplug_vld = 0; req_vld = 0; req_wr = 0;
        check({tag, " rsp_vld"},  32'(rsp_vld),  32'(e_vld));
        check({tag, " rsp_err"},  32'(rsp_err),  32'(e_err));
        check({tag, " rsp_data"}, 32'(rsp_data), 32'(e_data));
        check({tag, " gpe_set"},  32'(gpe_set),  32'(e_gpe));
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 32; a++) cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'(a), tag);
    endtask

    task automatic small_cycle(input logic pv, input logic [7:0] pid,
                               input logic rv, input logic [3:0] ra, input string tag);
        logic [7:0] e_data, e_gpe;
        logic       ok;
        ok     = pv && (pid / 8 < 16);
        e_data = rv ? s_model[ra*8 +: 8] : 8'h00;
        e_gpe  = exp_gpe(ok);
        if (ok) s_model[pid] = 1'b1;
        s_plug_vld = pv; s_plug_id = pid; s_req_vld = rv; s_req_addr = ra;
        @(negedge clk);
        s_plug_vld = 0; s_req_vld = 0;
        check({tag, " small rsp_data"}, 32'(s_rsp_data), 32'(e_data));
        check({tag, " small gpe_set"},  32'(s_gpe_set),  32'(e_gpe));
    endtask

    initial begin
        boot_map = boot_pattern();
        s_boot   = small_pattern();
        model    = boot_map;
        s_model  = s_boot;
        rst      = 1'b1;
        repeat (3) @(negedge clk);
        // R5 outputs quiet during reset
        check("R5 rsp_vld in reset", 32'(rsp_vld), 0);
        check("R5 gpe_set in reset", 32'(gpe_set), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5 gpe_set after reset", 32'(gpe_set), 0);
        check("R5 small gpe_set after reset", 32'(s_gpe_set), 0);
        // R5 boot load, R1 read window
        read_all("R5 R1 boot map");

        // R2 R3 boundary identifiers
        cycle(1, 8'd255, 0, 0, 0, 0, 2'd0, 0, "R2 plug 255");
        cycle(0, 0, 1, 8'd0, 1, 0, 2'd0, 5'd31, "R3 unplug 0 R1 read top byte");
        cycle(1, 8'd1, 0, 0, 1, 0, 2'd0, 5'd0, "R2 plug 1 R1 read byte 0 before edge");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd0, "R2 R3 byte 0 after");

        // R9 same identifier both ways
        cycle(1, 8'd77, 1, 8'd77, 0, 0, 2'd0, 0, "R9 same id");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd9, "R9 byte 9 cleared");
        // R10 different identifiers
        cycle(1, 8'd100, 1, 8'd99, 0, 0, 2'd0, 0, "R10 pair");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd12, "R10 byte 12");

        // R6 writes ignored
        cycle(0, 0, 0, 0, 1, 1, 2'd0, 5'd12, "R6 write byte 12");
        cycle(0, 0, 0, 0, 1, 1, 2'd0, 5'd0,  "R6 write byte 0");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd12, "R6 byte 12 after write");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd0,  "R6 byte 0 after write");

        // R7 non-byte sizes
        cycle(0, 0, 0, 0, 1, 0, 2'd1, 5'd4, "R7 half read");
        cycle(0, 0, 0, 0, 1, 0, 2'd2, 5'd4, "R7 word read");
        cycle(0, 0, 0, 0, 1, 1, 2'd3, 5'd4, "R7 reserved write");
        cycle(0, 0, 0, 0, 1, 0, 2'd0, 5'd4, "R7 byte 4 unchanged");

        // R11 idle cycles then full readback
        repeat (4) cycle(0, 0, 0, 0, 0, 0, 2'd0, 0, "R11 idle");
        read_all("R11 hold");

        // R8 rejection on reduced map, top in-range identifier accepted
        small_cycle(1, 8'd200, 0, 0, "R8 id 200 rejected");
        small_cycle(1, 8'd255, 0, 0, "R8 id 255 rejected");
        for (int a = 0; a < 16; a++) small_cycle(0, 0, 1, 4'(a), "R8 map unchanged");
        small_cycle(1, 8'd127, 0, 0, "R8 R2 id 127 accepted");
        small_cycle(0, 0, 1, 4'd15, "R8 R2 byte 15");

        // random mix: R1 R2 R3 R4 R9 R10
        begin
            int unsigned seed = 32'hC0FFEE;
            void'($urandom(seed));
            for (int n = 0; n < 600; n++) begin
                logic [7:0] p, u;
                logic       pv, uv, rv, rw;
                logic [1:0] rs;
                p  = 8'($urandom);
                u  = ($urandom % 4 == 0) ? p : 8'($urandom);
                pv = 1'($urandom);
                uv = 1'($urandom);
                rv = ($urandom % 4 != 0);
                rw = ($urandom % 6 == 0);
                rs = ($urandom % 8 == 0) ? 2'($urandom) : 2'd0;
                cycle(pv, p, uv, u, rv, rw, rs, 5'($urandom), "R1 R2 R3 R4 random");
            end
        end
        read_all("R2 R3 final map");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule